// File: doc/BRIEF.md
# Programmable System Clock Prescaler

This block derives the core clock of a small microcontroller from one of five oscillators. The oscillators sit outside the block. Each one is presented as a single-cycle tick strobe in the fast fabric clock domain `clk_i`. A 4-bit control register, written over a simple auxiliary register bus, sets three things: the oscillator, the divide ratio (2, 4, 8 or 16), and whether the peripheral clock keeps running while the core sleeps. When the internal RC oscillator 1 is not selected, a 2-bit oscillator-select input picks the source. That input comes from the system configuration register.

A write to the control register does not change the clock at once. It raises a busy flag and starts a synchronization cycle. The running clock completes its current period. The output is then held low, and the new source and ratio take over from the start of a fresh low phase. No pulse is shorter than half a period of either configuration. The prescaler output always has a 50% duty cycle.

The peripheral clock is the core clock passed through a gate. The gate's enable changes only while the core clock is low.

Top module: `sysclk_prescaler`

## Requirements
- R1: After reset the register holds 1111b, `busy_o` is 0, and `core_clk_o` runs from RC oscillator 1 divided by 8.
- R2: The register is written only when `wr_en_i` is high and `addr_i` equals 3. Bit 3 is keep-peripheral-in-sleep, bit 2 is RC1 select, and bits 1:0 are the rate code. A write to any other address changes nothing.
- R3: Rate codes select the divide ratio as follows: 00 gives 16, 11 gives 8, 10 gives 4 and 01 gives 2. High and low phases each last ratio/2 ticks of the selected source.
- R4: With RC1 select set to 1, `rc1_tick_i` drives the prescaler whatever the value of `osc_sel_i`. With it at 0, `osc_tick_i[osc_sel_i]` drives the prescaler.
- R5: `busy_o` rises in the cycle after a register write and stays high until the synchronization cycle has applied the settings.
- R6: New settings, including a snapshot of `osc_sel_i`, take effect only at the end of a low phase of the running clock. A change of `osc_sel_i` without a register write has no effect. No output pulse around a switch is shorter than the shorter half period of the two configurations.
- R7: A write while busy replaces the pending value. The value applied is the latest one written.
- R8: With keep-peripheral at 0 and `sleep_i` high, `per_clk_o` stays low. With keep-peripheral at 1, it keeps running during sleep. While awake, it follows `core_clk_o`.
- R9: The peripheral gate enable changes only in cycles where `core_clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register bus write strobe |
| addr_i | input | 4 | Register bus address |
| wdata_i | input | 4 | Register bus write data |
| osc_sel_i | input | 2 | Oscillator select from system configuration |
| osc_tick_i | input | 4 | Tick strobes of the four selectable oscillators |
| rc1_tick_i | input | 1 | Tick strobe of RC oscillator 1 |
| sleep_i | input | 1 | Core is in sleep |
| core_clk_o | output | 1 | Divided core clock |
| per_clk_o | output | 1 | Gated peripheral clock |
| busy_o | output | 1 | Synchronization in progress |

## Verification
The bench sweeps every source against every rate code and measures the high and low widths. A design with a wrong code table or a swapped source index would show the wrong width. A design with a duty error would show unequal halves.

It also switches from the slowest to the fastest ratio while tracking the shortest pulse. A design that applied settings at once would cut a phase short and leave a runt pulse.

Further cases cover:
- changing `osc_sel_i` with no write, which a design without a snapshot would follow at once;
- two back-to-back writes, where a design that latched the first value would run at the wrong rate;
- a write to a wrong address, which a design that decoded the address badly would accept;
- sleep with and without peripheral keep, which a reversed keep polarity would get wrong.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int N_OSC  = 4;
  localparam int OSEL_W = $clog2(N_OSC);
  localparam int REG_W  = 4;
  localparam int CNT_W  = 4;

  typedef struct packed {
    logic       keep_per;
    logic       use_rc1;
    logic [1:0] rate;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RST = 4'b1111;

  // source ticks per half period for each rate code
  function automatic logic [CNT_W-1:0] half_ticks(input logic [1:0] rate);
    case (rate)
      2'b00:   return CNT_W'(8);
      2'b11:   return CNT_W'(4);
      2'b10:   return CNT_W'(2);
      default: return CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/clk_cfg_reg.sv
module clk_cfg_reg
  import sysclk_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              done_i,
  output clk_cfg_t          cfg_o,
  output logic              busy_o
);
  clk_cfg_t cfg_q;
  logic     busy_q;
  logic     wr_hit;

  assign wr_hit = wr_en_i && (addr_i == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      busy_q <= 1'b0;
    end else if (wr_hit) begin
      cfg_q  <= clk_cfg_t'(wdata_i);
      busy_q <= 1'b1;
    end else if (done_i) begin
      busy_q <= 1'b0;
    end
  end

  assign cfg_o  = cfg_q;
  assign busy_o = busy_q;

  p_busy_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> busy_q);
  p_busy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> busy_q);
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(cfg_q));
endmodule

// File: rtl/clk_src_mux.sv
module clk_src_mux
  import sysclk_pkg::*;
(
  input  logic [N_OSC-1:0]  osc_tick_i,
  input  logic              rc1_tick_i,
  input  logic              use_rc1_i,
  input  logic [OSEL_W-1:0] osel_i,
  output logic              tick_o
);
  logic [N_OSC-1:0] hit;

  for (genvar k = 0; k < N_OSC; k++) begin : g_sel
    assign hit[k] = osc_tick_i[k] && (osel_i == OSEL_W'(k));
  end

  assign tick_o = use_rc1_i ? rc1_tick_i : |hit;
endmodule

// File: rtl/clk_div_sync.sv
module clk_div_sync
  import sysclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              busy_i,
  input  logic [1:0]        rate_i,
  input  logic              use_rc1_i,
  input  logic [OSEL_W-1:0] osel_i,
  output logic              act_rc1_o,
  output logic [OSEL_W-1:0] act_osel_o,
  output logic              clk_o,
  output logic              done_o
);
  logic [1:0]        rate_q;
  logic              rc1_q;
  logic [OSEL_W-1:0] osel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  half;
  logic              clk_q;
  logic              last;

  assign half   = half_ticks(rate_q);
  assign last   = (cnt_q == half - 1'b1);
  // switch only where a rising edge would have come
  assign done_o = tick_i && last && !clk_q && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= CFG_RST.rate;
      rc1_q  <= CFG_RST.use_rc1;
      osel_q <= '0;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
    end else if (tick_i) begin
      if (last) begin
        cnt_q <= '0;
        if (clk_q) begin
          clk_q <= 1'b0;
        end else if (busy_i) begin
          rate_q <= rate_i;
          rc1_q  <= use_rc1_i;
          osel_q <= osel_i;
        end else begin
          clk_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign act_rc1_o  = rc1_q;
  assign act_osel_o = osel_q;
  assign clk_o      = clk_q;

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half);
  p_edge_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_q) |-> $past(tick_i));
  p_switch_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({rate_q, rc1_q, osel_q}) |-> (!clk_q && !$past(clk_q)));
  p_switch_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({rate_q, rc1_q, osel_q}) |-> $past(busy_i));
endmodule

// File: rtl/per_clk_gate.sv
module per_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic core_clk_i,
  input  logic keep_i,
  input  logic sleep_i,
  output logic per_clk_o
);
  logic en_q;

  // enable only moves while the core clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= 1'b1;
    else if (!core_clk_i) en_q <= keep_i || !sleep_i;
  end

  assign per_clk_o = core_clk_i && en_q;

  p_gate_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> !$past(core_clk_i));
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import sysclk_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [OSEL_W-1:0] osc_sel_i,
  input  logic [N_OSC-1:0]  osc_tick_i,
  input  logic              rc1_tick_i,
  input  logic              sleep_i,
  output logic              core_clk_o,
  output logic              per_clk_o,
  output logic              busy_o
);
  clk_cfg_t          cfg;
  logic              busy;
  logic              done;
  logic              tick;
  logic              act_rc1;
  logic [OSEL_W-1:0] act_osel;
  logic              core_clk;

  clk_cfg_reg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .done_i  (done),
    .cfg_o   (cfg),
    .busy_o  (busy)
  );

  clk_src_mux u_mux (
    .osc_tick_i (osc_tick_i),
    .rc1_tick_i (rc1_tick_i),
    .use_rc1_i  (act_rc1),
    .osel_i     (act_osel),
    .tick_o     (tick)
  );

  clk_div_sync u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .busy_i     (busy),
    .rate_i     (cfg.rate),
    .use_rc1_i  (cfg.use_rc1),
    .osel_i     (osc_sel_i),
    .act_rc1_o  (act_rc1),
    .act_osel_o (act_osel),
    .clk_o      (core_clk),
    .done_o     (done)
  );

  per_clk_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_clk_i (core_clk),
    .keep_i     (cfg.keep_per),
    .sleep_i    (sleep_i),
    .per_clk_o  (per_clk_o)
  );

  assign core_clk_o = core_clk;
  assign busy_o     = busy;
endmodule

// File: tb/sim_sysclk_prescaler.sv
module sim_sysclk_prescaler;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [3:0] wdata_i = '0;
  logic [1:0] osc_sel_i = '0;
  logic [3:0] osc_tick_i;
  logic       rc1_tick_i;
  logic       sleep_i = 1'b0;
  logic       core_clk_o, per_clk_o, busy_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  sysclk_prescaler u0 (.*);

  // tick generators: oscillator k ticks every k+1 cycles, RC1 every 5
  int tcnt [5];
  initial for (int k = 0; k < 5; k++) tcnt[k] = 0;
  always @(negedge clk_i) begin
    for (int k = 0; k < 5; k++) tcnt[k] = (tcnt[k] + 1) % (k + 1);
  end
  always_comb begin
    for (int k = 0; k < 4; k++) osc_tick_i[k] = (tcnt[k] == k);
    rc1_tick_i = (tcnt[4] == 4);
  end

  // pulse-width monitor
  int run = 0, min_w = 9999;
  bit prev = 0, skip = 1;
  always @(negedge clk_i) begin
    if (core_clk_o == prev) run++;
    else begin
      if (!skip && run < min_w) min_w = run;
      skip = 0;
      run = 1;
    end
    prev = core_clk_o;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 4'(addr); wdata_i = 4'(data);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy_o && t < 5000) begin @(negedge clk_i); t++; end
  endtask

  task automatic measure(output int hi, output int lo);
    int t = 0;
    while (core_clk_o !== 1'b0 && t < 2000) begin @(negedge clk_i); t++; end
    while (core_clk_o !== 1'b1 && t < 2000) begin @(negedge clk_i); t++; end
    hi = 0; lo = 0;
    while (core_clk_o == 1'b1 && hi < 2000) begin hi++; @(negedge clk_i); end
    while (core_clk_o == 1'b0 && lo < 2000) begin lo++; @(negedge clk_i); end
  endtask

  function automatic int half_of(int code);
    case (code)
      0: return 8;
      3: return 4;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hi, lo, cnt, mis;
    repeat (3) @(negedge clk_i);
    check("R1 busy after reset", int'(busy_o), 0);
    check("R1 core low in reset", int'(core_clk_o), 0);
    rst_ni = 1'b1;
    measure(hi, lo);
    check("R1 reset high width", hi, 20);
    check("R1 reset low width", lo, 20);

    // R2: wrong address ignored
    wr(2, 0);
    check("R2 no busy on other addr", int'(busy_o), 0);
    measure(hi, lo);
    check("R2 period unchanged", hi, 20);

    // R3/R4 sweep: selectable oscillators then RC1
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 4; c++) begin
        int exp;
        osc_sel_i = (s < 4) ? 2'(s) : 2'd2;
        wr(3, ((s == 4) ? 4'b1100 : 4'b1000) | c);
        check("R5 busy after write", int'(busy_o), 1);
        wait_idle();
        exp = half_of(c) * (s + 1);
        measure(hi, lo);
        check($sformatf("R3 R4 src%0d code%0d high", s, c), hi, exp);
        check($sformatf("R3 R4 src%0d code%0d low", s, c), lo, exp);
      end
    end
    check("R5 busy cleared", int'(busy_o), 0);

    // R6: runt-free switch from /16 to /2 on oscillator 3
    osc_sel_i = 2'd3;
    wr(3, 4'b1000);
    wait_idle();
    measure(hi, lo);
    check("R6 slow setup", hi, 32);
    @(negedge clk_i); #1; min_w = 9999; skip = 1;
    wr(3, 4'b1001);
    wait_idle();
    measure(hi, lo);
    measure(hi, lo);
    check("R6 new width", hi, 4);
    check("R6 no runt", int'(min_w >= 4), 1);

    // R6: osc_sel change without a write is ignored
    osc_sel_i = 2'd0;
    wr(3, 4'b1001);
    wait_idle();
    measure(hi, lo);
    check("R6 snapshot osc0", hi, 1);
    osc_sel_i = 2'd3;
    repeat (10) @(negedge clk_i);
    measure(hi, lo);
    check("R6 sel change ignored", hi, 1);
    wr(3, 4'b1001);
    wait_idle();
    measure(hi, lo);
    check("R6 sel applied on write", hi, 4);

    // R7: back-to-back writes, latest wins
    wr(3, 4'b1100);
    wr(3, 4'b1101);
    check("R7 busy held", int'(busy_o), 1);
    wait_idle();
    measure(hi, lo);
    check("R7 latest rate", hi, 5);

    // R8: sleep with keep=1 runs
    sleep_i = 1'b1;
    repeat (50) @(negedge clk_i);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk_i); cnt += int'(per_clk_o); end
    check("R8 keep=1 runs in sleep", int'(cnt > 0), 1);
    // keep=0 stops
    wr(3, 4'b0101);
    wait_idle();
    repeat (50) @(negedge clk_i);
    cnt = 0; mis = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i); cnt += int'(per_clk_o); mis += int'(core_clk_o);
    end
    check("R8 keep=0 stopped in sleep", cnt, 0);
    check("R8 core still runs", int'(mis > 0), 1);
    // awake follows core
    sleep_i = 1'b0;
    repeat (50) @(negedge clk_i);
    mis = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i); mis += int'(per_clk_o != core_clk_o);
    end
    check("R8 awake follows core", mis, 0);

    // R9: peripheral never high while core low
    mis = 0;
    sleep_i = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i); mis += int'(per_clk_o && !core_clk_o);
    end
    sleep_i = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i); mis += int'(per_clk_o && !core_clk_o);
    end
    check("R9 gate clean", mis, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule